// File: doc/BRIEF.md
# Page Write Emulation Controller

This controller lets a host update individual bytes of a flash page as if the array were byte-erasable. An SPI front end opens a transfer with a command byte and a start address, then streams data bytes. When chip select is deasserted, the controller does the page-level work that a flash array needs.

For a page write, the controller first places the received bytes in a staging buffer that holds one full page. It then reads the array only at offsets that received no data. Next it erases the whole page and writes the full buffer back. As a result, bytes the host did not address keep their old values. Two other commands are supported. A program-only command can clear bits but never set them. An erase-only command sets the page to FFh.

The array is an external synchronous byte RAM with one cycle of read latency. Incoming data uses a valid/ready handshake. The front end must hold `in_data` stable while `in_valid` is high and `in_ready` is low. `in_ready` is high only while a write or program transfer is open. All other pins are plain control and status.

Top module: `pgw_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy`, `done`, `in_ready` and `arr_en` are all 0.
- R2: A page write (command 0Ah) stores each received byte at offset (start offset + byte index) within the addressed page. Every other byte of that page, and every other page, keeps its previous value.
- R3: Bytes received past the last offset of the page wrap to offset 0 of the same page. If two bytes land on the same offset, the one received later is the one stored.
- R4: During a page write, the controller reads the array only at offsets that received no data. The number of array reads therefore equals the page size minus the number of distinct offsets received.
- R5: A page write makes exactly two page-sized passes of array writes. The first pass writes FFh to every byte of the page. The second pass then writes the merged buffer.
- R6: A page program (command 02h) stores the old byte ANDed with the received byte at each received offset. No erase pass takes place: the controller reads every offset once and writes every offset once.
- R7: A page erase (command DBh) writes FFh to all bytes of the addressed page. It makes no array reads and no other writes.
- R8: `busy` goes high in the cycle after chip select rises, for any transfer that starts an operation. It stays high until the last array write. `done` pulses for one cycle in the same cycle that `busy` falls.
- R9: While `busy` is high, `in_ready` stays low and any new transfer is ignored.
- R10: If a write or program transfer closes with no data bytes received, it is dropped. `busy` stays low and the array is not accessed.
- R11: A transfer whose command byte is none of 0Ah, 02h or DBh is ignored. It takes no data and causes no array access.
- R12: During an erase transfer, `in_ready` stays low, so no data is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_open | input | 1 | One-cycle pulse: chip select fell and the command and address are valid |
| xfer_cmd | input | 8 | Command byte |
| xfer_addr | input | ADDR_W | Start byte address |
| xfer_close | input | 1 | One-cycle pulse: chip select rose |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Controller accepts a data byte |
| in_data | input | 8 | Data byte |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write (1) or read (0) |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, valid one cycle after a read |

## Verification
The bench targets several corner cases:
- **Wrap-around.** A transfer runs past the page end and covers every offset. A design that carried into the next page would corrupt that page. A design that did not overwrite duplicated offsets would leave the first byte in place. A fully covered page must also cause zero fill reads.
- **Fill skipping.** The bench counts array reads. A design that refilled addressed offsets would both read too often and overwrite the new data.
- **Erase ordering and program-only.** The bench checks that all erase writes come first. It also checks that a program command ANDs with the old byte rather than replacing it.
- **Dropped and rejected transfers.** Empty transfers, unknown commands and commands issued while busy must leave the array untouched.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_FILL,
    ST_ERASE,
    ST_PROG
  } pgw_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_WRITE,
    OP_PROG,
    OP_ERASE
  } pgw_op_e;

  localparam logic [7:0] CMD_PAGE_WRITE = 8'h0A;
  localparam logic [7:0] CMD_PAGE_PROG  = 8'h02;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'hDB;
  localparam logic [7:0] ERASED_BYTE    = 8'hFF;

  function automatic pgw_op_e decode_cmd(input logic [7:0] code);
    case (code)
      CMD_PAGE_WRITE: return OP_WRITE;
      CMD_PAGE_PROG:  return OP_PROG;
      CMD_PAGE_ERASE: return OP_ERASE;
      default:        return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pgw_stage_buf.sv
module pgw_stage_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             st_we,
  input  logic [OFF_W-1:0] st_off,
  input  logic [7:0]       st_data,
  input  logic             fl_we,
  input  logic [OFF_W-1:0] fl_off,
  input  logic [7:0]       fl_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_vld
);

  logic [7:0] slot_q [PAGE_BYTES];
  logic       seen_q [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 seen_q[i] <= 1'b0;
      else if (clr)                               seen_q[i] <= 1'b0;
      else if (st_we && st_off == OFF_W'(i))      seen_q[i] <= 1'b1;
    end

    // a filled slot that was also received is merged by AND (program-only case)
    always_ff @(posedge clk) begin
      if (st_we && st_off == OFF_W'(i))
        slot_q[i] <= st_data;
      else if (fl_we && fl_off == OFF_W'(i))
        slot_q[i] <= seen_q[i] ? (slot_q[i] & fl_data) : fl_data;
    end
  end

  assign rd_data = slot_q[rd_off];
  assign rd_vld  = seen_q[rd_off];

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = ADDR_W - OFF_W,
  localparam int CNT_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_open,
  input  logic [7:0]        xfer_cmd,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_close,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              busy,
  output logic              done,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata,
  output logic              buf_clr,
  output logic              buf_st_we,
  output logic [OFF_W-1:0]  buf_st_off,
  output logic [7:0]        buf_st_data,
  output logic              buf_fl_we,
  output logic [OFF_W-1:0]  buf_fl_off,
  output logic [7:0]        buf_fl_data,
  output logic [OFF_W-1:0]  buf_rd_off,
  input  logic [7:0]        buf_rd_data,
  input  logic              buf_rd_vld
);

  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAGE_BYTES - 1);

  pgw_state_e        state;
  pgw_op_e           op;
  logic [PG_W-1:0]   page;
  logic [OFF_W-1:0]  ptr;
  logic              got_any;
  logic [CNT_W-1:0]  cnt;
  logic              cap_vld;
  logic [OFF_W-1:0]  cap_off;

  logic accept, take, fill_issue, finish;

  assign accept     = (state == ST_IDLE) && xfer_open && (decode_cmd(xfer_cmd) != OP_NONE);
  assign in_ready   = (state == ST_RECV) && (op != OP_ERASE);
  assign take       = in_valid && in_ready;
  assign fill_issue = (state == ST_FILL) && (cnt != CNT_END) && ((op == OP_PROG) || !buf_rd_vld);
  assign finish     = (cnt == CNT_LAST) &&
                      (((state == ST_ERASE) && (op == OP_ERASE)) || (state == ST_PROG));

  assign buf_clr     = accept;
  assign buf_st_we   = take;
  assign buf_st_off  = ptr;
  assign buf_st_data = in_data;
  assign buf_fl_we   = cap_vld;
  assign buf_fl_off  = cap_off;
  assign buf_fl_data = arr_rdata;
  assign buf_rd_off  = cnt[OFF_W-1:0];

  assign busy      = (state == ST_FILL) || (state == ST_ERASE) || (state == ST_PROG);
  assign arr_en    = fill_issue || (state == ST_ERASE) || (state == ST_PROG);
  assign arr_we    = (state == ST_ERASE) || (state == ST_PROG);
  assign arr_addr  = {page, cnt[OFF_W-1:0]};
  assign arr_wdata = (state == ST_ERASE) ? ERASED_BYTE : buf_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op      <= OP_NONE;
      page    <= '0;
      ptr     <= '0;
      got_any <= 1'b0;
      cnt     <= '0;
      cap_vld <= 1'b0;
      cap_off <= '0;
      done    <= 1'b0;
    end else begin
      cap_vld <= fill_issue;
      cap_off <= cnt[OFF_W-1:0];
      done    <= finish;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RECV;
            op      <= decode_cmd(xfer_cmd);
            page    <= xfer_addr[ADDR_W-1:OFF_W];
            ptr     <= xfer_addr[OFF_W-1:0];
            got_any <= 1'b0;
          end
        end
        ST_RECV: begin
          if (take) begin
            ptr     <= ptr + 1'b1;
            got_any <= 1'b1;
          end
          if (xfer_close) begin
            cnt <= '0;
            if (op == OP_ERASE)        state <= ST_ERASE;
            else if (got_any || take)  state <= ST_FILL;
            else                       state <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (cnt == CNT_END) begin
            cnt   <= '0;
            state <= (op == OP_WRITE) ? ST_ERASE : ST_PROG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ERASE: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            state <= (op == OP_ERASE) ? ST_IDLE : ST_PROG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_open,
  input  logic [7:0]        xfer_cmd,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_close,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              busy,
  output logic              done,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic             b_clr, b_st_we, b_fl_we, b_rd_vld;
  logic [OFF_W-1:0] b_st_off, b_fl_off, b_rd_off;
  logic [7:0]       b_st_data, b_fl_data, b_rd_data;

  pgw_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_open  (xfer_open),
    .xfer_cmd   (xfer_cmd),
    .xfer_addr  (xfer_addr),
    .xfer_close (xfer_close),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .busy       (busy),
    .done       (done),
    .arr_en     (arr_en),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata),
    .arr_rdata  (arr_rdata),
    .buf_clr    (b_clr),
    .buf_st_we  (b_st_we),
    .buf_st_off (b_st_off),
    .buf_st_data(b_st_data),
    .buf_fl_we  (b_fl_we),
    .buf_fl_off (b_fl_off),
    .buf_fl_data(b_fl_data),
    .buf_rd_off (b_rd_off),
    .buf_rd_data(b_rd_data),
    .buf_rd_vld (b_rd_vld)
  );

  pgw_stage_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (b_clr),
    .st_we   (b_st_we),
    .st_off  (b_st_off),
    .st_data (b_st_data),
    .fl_we   (b_fl_we),
    .fl_off  (b_fl_off),
    .fl_data (b_fl_data),
    .rd_off  (b_rd_off),
    .rd_data (b_rd_data),
    .rd_vld  (b_rd_vld)
  );

endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_close,
  input logic              in_ready,
  input logic              busy,
  input logic              done,
  input logic              arr_en,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);

  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_array_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |-> busy);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_busy_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(xfer_close));

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFF_W]));

  p_write_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_en);

endmodule

bind pgw_ctrl pgw_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_close (xfer_close),
  .in_ready   (in_ready),
  .busy       (busy),
  .done       (done),
  .arr_en     (arr_en),
  .arr_we     (arr_we),
  .arr_addr   (arr_addr)
);

// File: tb/pgw_ctrl_bench.sv
module pgw_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 10;
  localparam int PG   = 256;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xfer_open = 1'b0, xfer_close = 1'b0;
  logic [7:0]    xfer_cmd = 8'h00;
  logic [AW-1:0] xfer_addr = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready, busy, done, arr_en, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;
  logic [7:0]    arr_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgw_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PG)) u_pgw_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_open(xfer_open), .xfer_cmd(xfer_cmd),
    .xfer_addr(xfer_addr), .xfer_close(xfer_close), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .busy(busy), .done(done),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // array model and traffic monitor
  logic [7:0] mem [MEMN];
  logic [7:0] exp_mem [MEMN];
  logic       preload = 1'b0;
  logic       clr_mon = 1'b0;
  int         rd_n, wr_n, ff_head, order_bad;

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (arr_en) begin
      if (arr_we) mem[arr_addr] <= arr_wdata;
      else        arr_rdata <= mem[arr_addr];
    end
  end

  always @(posedge clk) begin
    if (clr_mon) begin
      rd_n <= 0; wr_n <= 0; ff_head <= 0; order_bad <= 0;
    end else if (arr_en) begin
      if (arr_we) begin
        wr_n <= wr_n + 1;
        if (wr_n < PG && arr_wdata == 8'hFF) ff_head <= ff_head + 1;
        if (wr_n < PG && int'(arr_addr[7:0]) != wr_n) order_bad <= order_bad + 1;
      end else begin
        rd_n <= rd_n + 1;
      end
    end
  end

  logic [7:0] pay [0:511];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); clr_mon = 1'b1;
    @(negedge clk); clr_mon = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic open_xfer(input logic [7:0] cmd, input logic [AW-1:0] addr);
    @(negedge clk);
    xfer_open = 1'b1; xfer_cmd = cmd; xfer_addr = addr;
    @(negedge clk);
    xfer_open = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_data = pay[k];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic close_xfer();
    xfer_close = 1'b1;
    @(negedge clk);
    xfer_close = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(done === 1'b1, req, int'(done), 1);
    check(busy === 1'b0, req, int'(busy), 0);
  endtask

  // expected effect of write/program on the model
  task automatic model_data(input bit is_prog, input logic [AW-1:0] addr, input int n,
                            output int distinct);
    logic [7:0] last [PG];
    bit         hit  [PG];
    int base = int'(addr) & ~(PG - 1);
    distinct = 0;
    for (int o = 0; o < PG; o++) hit[o] = 1'b0;
    for (int k = 0; k < n; k++) begin
      int o = (int'(addr) + k) % PG;
      last[o] = pay[k];
      hit[o] = 1'b1;
    end
    for (int o = 0; o < PG; o++) if (hit[o]) begin
      distinct++;
      exp_mem[base + o] = is_prog ? (exp_mem[base + o] & last[o]) : last[o];
    end
  endtask

  task automatic run_write(input logic [AW-1:0] addr, input int n, input string tag);
    int distinct;
    clear_mon();
    model_data(1'b0, addr, n, distinct);
    open_xfer(8'h0A, addr);
    send_bytes(n);
    close_xfer();
    check(busy === 1'b1, "R8 busy after close", int'(busy), 1);
    wait_done("R8 done ends busy");
    @(negedge clk);
    check(rd_n == PG - distinct, {"R4 fill reads ", tag}, rd_n, PG - distinct);
    check(wr_n == 2 * PG, {"R5 write count ", tag}, wr_n, 2 * PG);
    check(ff_head == PG && order_bad == 0, {"R5 erase first ", tag}, ff_head, PG);
    compare_mem({"R2 page contents ", tag});
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0, "R1 status in reset", int'({busy, done}), 0);
    check(in_ready === 1'b0 && arr_en === 1'b0, "R1 ready/array in reset",
          int'({in_ready, arr_en}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && in_ready === 1'b0 && arr_en === 1'b0, "R1 after reset",
          int'({busy, in_ready, arr_en}), 0);
  endtask

  task automatic t_two_bytes();
    pay[0] = 8'hAA; pay[1] = 8'h55;
    run_write(AW'(PG + 2), 2, "two bytes");
  endtask

  task automatic t_wrap_partial();
    for (int k = 0; k < 10; k++) pay[k] = 8'(k * 11 + 1);
    run_write(AW'(2 * PG + 250), 10, "R3 wrap partial");
  endtask

  task automatic t_wrap_full();
    for (int k = 0; k < 260; k++) pay[k] = 8'(k * 3 + 9);
    run_write(AW'(3 * PG + 254), 260, "R3 wrap overwrite");
  endtask

  task automatic t_program();
    int distinct;
    for (int k = 0; k < 4; k++) pay[k] = 8'(8'hF0 >> k) | 8'h05;
    clear_mon();
    model_data(1'b1, AW'(PG + 16), 4, distinct);
    open_xfer(8'h02, AW'(PG + 16));
    send_bytes(4);
    close_xfer();
    wait_done("R6 program done");
    @(negedge clk);
    check(rd_n == PG, "R6 program reads", rd_n, PG);
    check(wr_n == PG, "R6 program no erase pass", wr_n, PG);
    compare_mem("R6 program AND result");
  endtask

  task automatic t_erase();
    clear_mon();
    for (int o = 0; o < PG; o++) exp_mem[o] = 8'hFF;
    open_xfer(8'hDB, AW'(37));
    in_valid = 1'b1; in_data = 8'h12;
    check(in_ready === 1'b0, "R12 erase takes no data", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready === 1'b0, "R12 erase takes no data", int'(in_ready), 0);
    in_valid = 1'b0;
    close_xfer();
    wait_done("R7 erase done");
    @(negedge clk);
    check(rd_n == 0 && wr_n == PG && ff_head == PG, "R7 erase traffic", wr_n, PG);
    compare_mem("R7 erase page");
  endtask

  task automatic t_empty();
    clear_mon();
    open_xfer(8'h0A, AW'(5));
    close_xfer();
    for (int k = 0; k < 6; k++) begin
      if (busy !== 1'b0) begin check(1'b0, "R10 busy stays low", int'(busy), 0); break; end
      @(negedge clk);
    end
    check(rd_n + wr_n == 0, "R10 no array access", rd_n + wr_n, 0);
    compare_mem("R10 memory unchanged");
  endtask

  task automatic t_unknown();
    clear_mon();
    open_xfer(8'h03, AW'(PG));
    check(in_ready === 1'b0, "R11 no data for unknown cmd", int'(in_ready), 0);
    close_xfer();
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && rd_n + wr_n == 0, "R11 unknown ignored", rd_n + wr_n, 0);
  endtask

  task automatic t_busy_refuse();
    int distinct;
    int ready_seen = 0;
    pay[0] = 8'h3C;
    clear_mon();
    model_data(1'b0, AW'(2 * PG + 100), 1, distinct);
    open_xfer(8'h0A, AW'(2 * PG + 100));
    send_bytes(1);
    close_xfer();
    xfer_open = 1'b1; xfer_cmd = 8'hDB; xfer_addr = AW'(3 * PG);
    in_valid = 1'b1; in_data = 8'h00;
    for (int k = 0; k < 40; k++) begin
      if (in_ready) ready_seen++;
      @(negedge clk);
    end
    xfer_open = 1'b0; in_valid = 1'b0;
    check(ready_seen == 0, "R9 ready low while busy", ready_seen, 0);
    wait_done("R9 original op completes");
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R9 refused command never starts", int'(busy), 0);
    compare_mem("R9 only original page changed");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMN; i++) exp_mem[i] = 8'(i * 7 + 3);
    preload = 1'b1;
    repeat (2) @(negedge clk);
    preload = 1'b0;
    t_reset();
    t_two_bytes();
    t_wrap_partial();
    t_wrap_full();
    t_program();
    t_erase();
    t_empty();
    t_unknown();
    t_busy_refuse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule